// File: doc/BRIEF.md
# Power-State Request Admission Filter

This block sits behind the receive side of a device function and judges each incoming request against the function's present power state. A request arrives as a one-cycle valid strobe with a type code and a message code. The block answers it one clock later with exactly one of two indications: accept, or reject with Unsupported Request. The single exception is a message that is neither accepted nor rejected but dropped without a report.

The verdict depends on the power sub-state as well as on the memory and I/O space enables. The same memory read can be accepted while the function is fully active and rejected once it has been put to sleep. The block also registers a bus-master-allowed indication. This indication lets device-initiated DMA proceed only while the function is fully active and bus mastering is enabled. Packet parsing and completion building belong to neighbouring logic.

Top module: `pwr_req_gate`

Encodings used throughout: request kind 0 = memory read, 1 = memory write, 2 = I/O read, 3 = I/O write, 4 = configuration read, 5 = configuration write, 6 = message, 7 = reserved. Power state 0 = full-on uninitialized, 1 = full-on active, 2 = light sleep (D1), 3 = deep sleep (D2), 4 = D3hot. Codes 5 to 7 are handled exactly as D3hot. The turn-off broadcast message code is the parameter `TURN_OFF_CODE`, default 8'h19.

## Requirements
- R1: While reset is held, a clock edge drives accept, unsupported-request and bus-master-allowed low.
- R2: In full-on active state (1), configuration requests (kinds 4, 5) and messages (kind 6) are accepted. Memory requests (kinds 0, 1) are accepted when memory space enable is 1. I/O requests (kinds 2, 3) are accepted when I/O space enable is 1.
- R3: In full-on active state, a memory request with memory space enable 0 gets Unsupported Request, and so does an I/O request with I/O space enable 0. Each enable affects only its own request kinds.
- R4: In full-on uninitialized state (0), configuration requests are accepted. Memory, I/O and message requests get Unsupported Request whatever the space enables are.
- R5: In states 2 and 3, configuration requests and messages of any code are accepted. Memory and I/O requests get Unsupported Request whatever the space enables are.
- R6: In D3hot (4), configuration requests and messages whose code equals `TURN_OFF_CODE` are accepted. Memory and I/O requests get Unsupported Request whatever the space enables are.
- R7: In D3hot, a message with any other code is dropped: neither accept nor unsupported-request rises for it.
- R8: Accept and unsupported-request are registered and appear in the cycle after the valid strobe. Both are low in a cycle that follows no valid request, and the two are never high together.
- R9: Bus-master-allowed is registered. It is high in the cycle after an edge at which the state was 1 and bus master enable was 1, and low otherwise, including in D3hot with bus master enable 1.
- R10: A reserved kind (7) gets Unsupported Request in every state. State codes 5 to 7 give the same verdicts as D3hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld_i | input | 1 | One request is present this cycle |
| req_kind_i | input | 3 | Request kind code |
| req_msg_code_i | input | MSG_W (8) | Message code, meaningful for kind 6 |
| dev_state_i | input | 3 | Present power state code |
| mem_space_en_i | input | 1 | Memory space decoding enabled |
| io_space_en_i | input | 1 | I/O space decoding enabled |
| bus_master_en_i | input | 1 | Bus mastering enabled by software |
| acc_o | output | 1 | Request of previous cycle accepted |
| ur_o | output | 1 | Request of previous cycle answered with Unsupported Request |
| bm_allow_o | output | 1 | Device-initiated DMA permitted |

## Verification
The bound assertions check several rules on every cycle. Accept and unsupported-request are mutually exclusive and stay quiet after idle cycles. Every request that is not a D3hot stray message gets exactly one answer. Configuration requests are accepted in every state, and memory and I/O requests are refused in D3hot and in uninitialized full-on. Strays are dropped, and DMA is never allowed in D3hot. The directed scenarios cover the rest. These are the dependence of memory and I/O verdicts on their own enables in the active state, message admission in the sleep states, back-to-back requests whose state changes between cycles, the treatment of codes 5 to 7 and of the reserved kind, and the one-cycle registration of bus-master-allowed.

// File: rtl/pwr_gate_pkg.sv
// Package: shared widths, encodings and types for the power-state request
// admission filter. Assumes the request kind and state codes listed in the
// brief; any state code above D3hot is folded into D3hot by the policy.
package pwr_gate_pkg;

    localparam int KIND_W    = 3;
    localparam int STATE_W   = 3;
    localparam int NUM_KINDS = 1 << KIND_W;

    // Power state codes as presented on dev_state_i.
    typedef enum logic [STATE_W-1:0] {
        S_D0_UNINIT = 3'd0,
        S_D0_ACT    = 3'd1,
        S_D1        = 3'd2,
        S_D2        = 3'd3,
        S_D3HOT     = 3'd4
    } pstate_e;

    // Request kind codes as presented on req_kind_i.
    typedef enum logic [KIND_W-1:0] {
        K_MEM_RD = 3'd0,
        K_MEM_WR = 3'd1,
        K_IO_RD  = 3'd2,
        K_IO_WR  = 3'd3,
        K_CFG_RD = 3'd4,
        K_CFG_WR = 3'd5,
        K_MSG    = 3'd6,
        K_RSVD   = 3'd7
    } req_kind_e;

    // One-hot classification of the current request (all zero when idle).
    typedef struct packed {
        logic mem;
        logic io;
        logic cfg;
        logic msg;
        logic rsvd;
        logic turn_off;   // qualifier on msg: code matches the turn-off broadcast
    } req_class_t;

    // Outcome of the admission decision for one cycle.
    typedef enum logic [1:0] {
        V_NONE   = 2'd0,
        V_ACCEPT = 2'd1,
        V_REJECT = 2'd2,
        V_DROP   = 2'd3
    } verdict_e;

endpackage

// File: rtl/pwr_req_decode.sv
// Module: pwr_req_decode
// Turns the raw request kind and message code into a class vector.
// Assumes at most one request per cycle; produces all-zero when no request
// is valid. Purely combinational.
module pwr_req_decode
    import pwr_gate_pkg::*;
#(
    parameter int          MSG_W         = 8,
    parameter logic [MSG_W-1:0] TURN_OFF_CODE = 8'h19
) (
    input  logic              vld_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [MSG_W-1:0]  code_i,
    output req_class_t        cls_o
);

    logic [NUM_KINDS-1:0] kind_hit;

    // One comparator per kind code, qualified by the request strobe.
    genvar g;
    generate
        for (g = 0; g < NUM_KINDS; g++) begin : g_kind_hit
            assign kind_hit[g] = vld_i && (kind_i == KIND_W'(g));
        end
    endgenerate

    // Group the per-code hits into request classes.
    always_comb begin
        cls_o          = '0;
        cls_o.mem      = kind_hit[K_MEM_RD] | kind_hit[K_MEM_WR];
        cls_o.io       = kind_hit[K_IO_RD]  | kind_hit[K_IO_WR];
        cls_o.cfg      = kind_hit[K_CFG_RD] | kind_hit[K_CFG_WR];
        cls_o.msg      = kind_hit[K_MSG];
        cls_o.rsvd     = kind_hit[K_RSVD];
        cls_o.turn_off = kind_hit[K_MSG] && (code_i == TURN_OFF_CODE);
    end

endmodule

// File: rtl/pwr_state_policy.sv
// Module: pwr_state_policy
// Decides accept / reject / drop for a classified request from the present
// power state and the space enables, and computes whether DMA is permitted.
// Assumes cls_i is one-hot or zero. State codes above D3hot are treated as
// D3hot. Purely combinational.
module pwr_state_policy
    import pwr_gate_pkg::*;
(
    input  logic [STATE_W-1:0] state_i,
    input  logic               mem_en_i,
    input  logic               io_en_i,
    input  logic               bm_en_i,
    input  req_class_t         cls_i,
    output verdict_e           verdict_o,
    output logic               bm_ok_o
);

    logic st_d0u;
    logic st_d0a;
    logic st_sleep;
    logic st_d3;

    // Fold the state code into the four policy groups.
    always_comb begin
        st_d0u   = (state_i == S_D0_UNINIT);
        st_d0a   = (state_i == S_D0_ACT);
        st_sleep = (state_i == S_D1) || (state_i == S_D2);
        st_d3    = !(st_d0u || st_d0a || st_sleep);
    end

    // Admission decision for the current request, by class and state group.
    always_comb begin
        verdict_o = V_NONE;
        if (cls_i.cfg) begin
            verdict_o = V_ACCEPT;
        end else if (cls_i.rsvd) begin
            verdict_o = V_REJECT;
        end else if (cls_i.mem) begin
            verdict_o = (st_d0a && mem_en_i) ? V_ACCEPT : V_REJECT;
        end else if (cls_i.io) begin
            verdict_o = (st_d0a && io_en_i) ? V_ACCEPT : V_REJECT;
        end else if (cls_i.msg) begin
            if (st_d0u)
                verdict_o = V_REJECT;
            else if (st_d3)
                verdict_o = cls_i.turn_off ? V_ACCEPT : V_DROP;
            else
                verdict_o = V_ACCEPT;
        end
    end

    // DMA is permitted only while fully active with bus mastering enabled.
    always_comb bm_ok_o = st_d0a && bm_en_i;

endmodule

// File: rtl/pwr_verdict_reg.sv
// Module: pwr_verdict_reg
// Registers the verdict into the accept and unsupported-request strobes and
// registers the DMA permission. Synchronous active-low reset clears all.
// A dropped request produces no strobe.
module pwr_verdict_reg
    import pwr_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_e verdict_i,
    input  logic     bm_ok_i,
    output logic     acc_o,
    output logic     ur_o,
    output logic     bm_allow_o
);

    // Output stage: one register per indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o      <= 1'b0;
            ur_o       <= 1'b0;
            bm_allow_o <= 1'b0;
        end else begin
            acc_o      <= (verdict_i == V_ACCEPT);
            ur_o       <= (verdict_i == V_REJECT);
            bm_allow_o <= bm_ok_i;
        end
    end

endmodule

// File: rtl/pwr_req_gate.sv
// Module: pwr_req_gate (top)
// Power-state request admission filter. One request per cycle is decoded,
// judged against the power state and space enables, and answered one cycle
// later with accept or Unsupported Request (or silently dropped for stray
// messages in D3hot). Also registers a DMA permission indication.
// Assumes inputs are synchronous to clk.
module pwr_req_gate
    import pwr_gate_pkg::*;
#(
    parameter int               MSG_W         = 8,
    parameter logic [MSG_W-1:0] TURN_OFF_CODE = 8'h19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld_i,
    input  logic [KIND_W-1:0]  req_kind_i,
    input  logic [MSG_W-1:0]   req_msg_code_i,
    input  logic [STATE_W-1:0] dev_state_i,
    input  logic               mem_space_en_i,
    input  logic               io_space_en_i,
    input  logic               bus_master_en_i,
    output logic               acc_o,
    output logic               ur_o,
    output logic               bm_allow_o
);

    req_class_t req_cls;
    verdict_e   verdict;
    logic       bm_ok;

    // Classify the incoming request.
    pwr_req_decode #(
        .MSG_W        (MSG_W),
        .TURN_OFF_CODE(TURN_OFF_CODE)
    ) decode_i (
        .vld_i (req_vld_i),
        .kind_i(req_kind_i),
        .code_i(req_msg_code_i),
        .cls_o (req_cls)
    );

    // Judge it against the power state.
    pwr_state_policy policy_i (
        .state_i  (dev_state_i),
        .mem_en_i (mem_space_en_i),
        .io_en_i  (io_space_en_i),
        .bm_en_i  (bus_master_en_i),
        .cls_i    (req_cls),
        .verdict_o(verdict),
        .bm_ok_o  (bm_ok)
    );

    // Register the outcome.
    pwr_verdict_reg out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .verdict_i (verdict),
        .bm_ok_i   (bm_ok),
        .acc_o     (acc_o),
        .ur_o      (ur_o),
        .bm_allow_o(bm_allow_o)
    );

endmodule

// File: rtl/pwr_req_gate_chk.sv
// Module: pwr_req_gate_chk
// Assertion checker bound to pwr_req_gate. Observes ports only.
module pwr_req_gate_chk
    import pwr_gate_pkg::*;
#(
    parameter int               MSG_W         = 8,
    parameter logic [MSG_W-1:0] TURN_OFF_CODE = 8'h19
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_vld_i,
    input logic [KIND_W-1:0]  req_kind_i,
    input logic [MSG_W-1:0]   req_msg_code_i,
    input logic [STATE_W-1:0] dev_state_i,
    input logic               mem_space_en_i,
    input logic               io_space_en_i,
    input logic               bus_master_en_i,
    input logic               acc_o,
    input logic               ur_o,
    input logic               bm_allow_o
);

    logic in_d3;
    logic is_cfg;
    logic is_memio;
    logic is_stray;

    // Observation helpers derived from the input ports.
    always_comb begin
        in_d3    = (dev_state_i >= S_D3HOT);
        is_cfg   = (req_kind_i == K_CFG_RD) || (req_kind_i == K_CFG_WR);
        is_memio = (req_kind_i <= K_IO_WR);
        is_stray = in_d3 && (req_kind_i == K_MSG) && (req_msg_code_i != TURN_OFF_CODE);
    end

    // R8: never both strobes at once
    p_one_hot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_o && ur_o));

    // R8: idle cycle yields no strobe
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_i |=> (!acc_o && !ur_o));

    // R8: every non-stray request is answered next cycle
    p_answered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && !is_stray) |=> (acc_o || ur_o));

    // R4: configuration accepted in every state
    p_cfg_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && is_cfg) |=> acc_o);

    // R4: uninitialized full-on refuses everything but configuration
    p_d0u_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && !is_cfg && dev_state_i == S_D0_UNINIT) |=> ur_o);

    // R6: memory and I/O refused in D3hot
    p_d3_memio_ur_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && is_memio && in_d3) |=> ur_o);

    // R7: stray messages in D3hot are dropped
    p_d3_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && is_stray) |=> (!acc_o && !ur_o));

    // R9: no DMA permission after a D3hot cycle
    p_d3_no_dma_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_d3 |=> !bm_allow_o);

    // R9: DMA permission follows enable in the active state
    p_dma_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_state_i == S_D0_ACT && bus_master_en_i) |=> bm_allow_o);

endmodule

bind pwr_req_gate pwr_req_gate_chk #(
    .MSG_W        (MSG_W),
    .TURN_OFF_CODE(TURN_OFF_CODE)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_vld_i      (req_vld_i),
    .req_kind_i     (req_kind_i),
    .req_msg_code_i (req_msg_code_i),
    .dev_state_i    (dev_state_i),
    .mem_space_en_i (mem_space_en_i),
    .io_space_en_i  (io_space_en_i),
    .bus_master_en_i(bus_master_en_i),
    .acc_o          (acc_o),
    .ur_o           (ur_o),
    .bm_allow_o     (bm_allow_o)
);

// File: tb/pwr_req_gate_tb_top.sv
`timescale 1ns/1ps
// Directed bench for pwr_req_gate: one task per scenario, each self-checking.
module pwr_req_gate_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_vld = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [7:0] req_code = 8'h00;
    logic [2:0] dev_state = 3'd0;
    logic       mem_en = 1'b0;
    logic       io_en = 1'b0;
    logic       bm_en = 1'b0;
    logic       acc;
    logic       ur;
    logic       bm_allow;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    localparam logic [7:0] TURN_OFF = 8'h19;

    always #4 clk = ~clk;   // 125 MHz

    pwr_req_gate #(.MSG_W(8), .TURN_OFF_CODE(TURN_OFF)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_vld_i      (req_vld),
        .req_kind_i     (req_kind),
        .req_msg_code_i (req_code),
        .dev_state_i    (dev_state),
        .mem_space_en_i (mem_en),
        .io_space_en_i  (io_en),
        .bus_master_en_i(bm_en),
        .acc_o          (acc),
        .ur_o           (ur),
        .bm_allow_o     (bm_allow)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge, check the answer one edge later.
    task automatic send(input string tag, input logic [2:0] k, input logic [7:0] code,
                        input logic [2:0] st, input logic me, input logic ie, input logic be,
                        input logic exp_acc, input logic exp_ur);
        @(negedge clk);
        req_vld = 1'b1; req_kind = k; req_code = code;
        dev_state = st; mem_en = me; io_en = ie; bm_en = be;
        @(negedge clk);
        req_vld = 1'b0;
        check(tag, "acc", acc, exp_acc);
        check(tag, "ur", ur, exp_ur);
        check(tag, "bm_allow", bm_allow, (st == 3'd1) && be);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        bm_en = 1'b1; dev_state = 3'd1; req_vld = 1'b1; req_kind = 3'd4;
        repeat (3) @(negedge clk);
        check("R1", "acc", acc, 1'b0);
        check("R1", "ur", ur, 1'b0);
        check("R1", "bm_allow", bm_allow, 1'b0);
        req_vld = 1'b0; bm_en = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_d0_active();
        for (int k = 0; k < 7; k++)
            send("R2", 3'(k), 8'h7e, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_space_enables();
        send("R3", 3'd0, 8'h00, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        send("R3", 3'd1, 8'h00, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        send("R3", 3'd2, 8'h00, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        send("R3", 3'd3, 8'h00, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        send("R3", 3'd0, 8'h00, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_d0_uninit();
        send("R4", 3'd4, 8'h00, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        send("R4", 3'd5, 8'h00, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        send("R4", 3'd0, 8'h00, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        send("R4", 3'd3, 8'h00, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        send("R4", 3'd6, 8'h20, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_sleep();
        for (int s = 2; s <= 3; s++) begin
            send("R5", 3'd5, 8'h00, 3'(s), 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
            send("R5", 3'd6, 8'h20, 3'(s), 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
            send("R5", 3'd6, TURN_OFF, 3'(s), 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
            send("R5", 3'd1, 8'h00, 3'(s), 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
            send("R5", 3'd2, 8'h00, 3'(s), 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        end
    endtask

    task automatic t_d3hot();
        send("R6", 3'd4, 8'h00, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        send("R6", 3'd6, TURN_OFF, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        send("R6", 3'd0, 8'h00, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        send("R6", 3'd3, 8'h00, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        // R9: DMA refused in D3hot even with bus mastering enabled (checked in send)
        send("R9", 3'd5, 8'h00, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_d3_drop();
        send("R7", 3'd6, 8'h18, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        send("R7", 3'd6, 8'h1a, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_timing();
        // R8: back-to-back requests with a state change between them
        @(negedge clk);
        req_vld = 1'b1; req_kind = 3'd0; dev_state = 3'd1; mem_en = 1'b1; io_en = 1'b0; bm_en = 1'b1;
        @(negedge clk);
        check("R8", "acc first", acc, 1'b1);
        check("R8", "ur first", ur, 1'b0);
        check("R9", "bm_allow active", bm_allow, 1'b1);
        req_kind = 3'd0; dev_state = 3'd4;
        @(negedge clk);
        check("R8", "acc second", acc, 1'b0);
        check("R8", "ur second", ur, 1'b1);
        check("R9", "bm_allow after D3", bm_allow, 1'b0);
        req_vld = 1'b0; dev_state = 3'd1;
        @(negedge clk);
        check("R8", "acc idle", acc, 1'b0);
        check("R8", "ur idle", ur, 1'b0);
        check("R9", "bm_allow back", bm_allow, 1'b1);
        bm_en = 1'b0;
        @(negedge clk);
        check("R9", "bm_allow disabled", bm_allow, 1'b0);
    endtask

    task automatic t_reserved_and_alias();
        for (int s = 0; s < 8; s++)
            send("R10", 3'd7, 8'h00, 3'(s), 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        for (int s = 5; s < 8; s++) begin
            send("R10", 3'd6, TURN_OFF, 3'(s), 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
            send("R10", 3'd6, 8'h33, 3'(s), 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
            send("R10", 3'd1, 8'h00, 3'(s), 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        end
    endtask

    initial begin
        t_reset();
        t_d0_active();
        t_space_enables();
        t_d0_uninit();
        t_sleep();
        t_d3hot();
        t_d3_drop();
        t_timing();
        t_reserved_and_alias();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule